// File: doc/BRIEF.md
# Periodic Signal Statistics Monitor

This block watches a stream of signed 14-bit samples, one per clock while enabled, and reduces each fixed-length window of samples to a single figure. Three statistics are selectable: the largest magnitude seen in the window, the mean-square power, or the number of samples whose magnitude is above a programmable threshold. At the end of every window the figure moves into a 20-bit result register, and a one-cycle ready strobe goes with it. An automatic gain control loop would read the result on each strobe and use it to adjust the front-end gain.

The window length is a 24-bit count of enabled samples. A down-counting timer is armed by the first sample of each window. The sample that closes a window transfers the result. The very next sample opens the following window and seeds the accumulator directly, so no sample is lost between windows. A synchronization input, when allowed, abandons the current window and starts a new one at once, so that several monitors can be aligned.

Top module: `stat_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `result` is 0 and `result_stb` is 0.
- R2: With `en` held high, `result_stb` pulses for exactly one cycle after every P-th consumed sample. P is the effective window length. The window that follows begins with the very next sample, with no idle cycle.
- R3: When `mode` is 2'b01, the result is the largest 13-bit magnitude in the window, zero-extended. The magnitude of a sample is its absolute value. The most negative input, -8192, counts as 8191.
- R4: When `mode` is 2'b00, each magnitude is squared and shifted right by 15 bits, which keeps its upper 11 bits. The terms are summed into a 24-bit accumulator that saturates at 2^24-1. The result is bits [23:4] of the accumulator.
- R5: When `mode[1]` is 1, the result is the number of samples in the window whose magnitude is strictly greater than `thresh`. A magnitude equal to the threshold is not counted.
- R6: A `period` value below 128 is treated as 128. The window length is captured when the window opens.
- R7: While `en` is low, no sample is consumed, `result_stb` stays 0 and `result` holds. The first enabled sample afterwards opens a fresh window.
- R8: When `sync_en` is high, an enabled sample with `sync_in` high discards the partial window and becomes the first sample of a new window, with no strobe. When `sync_en` is low, `sync_in` has no effect.
- R9: `result` changes only in a cycle in which `result_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Consume the current sample |
| sync_en | input | 1 | Allow `sync_in` to restart the window |
| sync_in | input | 1 | Window restart pulse |
| sample | input | 14 | Two's complement input sample |
| period | input | 24 | Window length in samples |
| mode | input | 2 | 00 power, 01 peak, 1x threshold count |
| thresh | input | 13 | Magnitude threshold for count mode |
| result | output | 20 | Statistic of the last completed window |
| result_stb | output | 1 | One-cycle pulse when `result` is updated |

## Verification
A timer that is off by one shows up at the strobe spacing within a single window. From then on, every later strobe is misplaced too. A wrong seed or fold in the accumulator stays hidden until the window closes, and then corrupts exactly one result value. A stale accumulator leaking across the boundary also spoils the next window. That is why every strobe is compared with a window computed independently in the bench. A restart that is handled wrongly shows one window later, as a strobe at the wrong cycle.

// File: rtl/stat_monitor_pkg.sv
package stat_monitor_pkg;
  typedef enum logic [1:0] {
    MODE_POWER = 2'b00,
    MODE_PEAK  = 2'b01,
    MODE_CNT_A = 2'b10,
    MODE_CNT_B = 2'b11
  } stat_mode_e;
endpackage

// File: rtl/stat_mag.sv
module stat_mag #(
  parameter int SAMPLE_W = 14,
  parameter int MAG_W    = 13
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [MAG_W-1:0]    mag
);
  logic [SAMPLE_W-1:0] abs_v;
  always_comb begin
    abs_v = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
    if (abs_v[SAMPLE_W-1]) mag = '1;
    else                   mag = abs_v[MAG_W-1:0];
  end
endmodule

// File: rtl/stat_timer.sv
module stat_timer #(
  parameter int PERIOD_W   = 24,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                sync_hit,
  input  logic [PERIOD_W-1:0] period,
  output logic                first,
  output logic                last
);
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

  logic [PERIOD_W-1:0] cnt_q;
  logic                seed_q;
  logic [PERIOD_W-1:0] eff_p;

  assign eff_p = (period < MIN_P) ? MIN_P : period;
  assign first = seed_q || sync_hit;
  assign last  = en && !first && (cnt_q == PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seed_q <= 1'b1;
    end else if (!en) begin
      seed_q <= 1'b1;
    end else if (first) begin
      cnt_q  <= eff_p - 1'b1;
      seed_q <= 1'b0;
    end else if (cnt_q == PERIOD_W'(1)) begin
      seed_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/stat_accum.sv
module stat_accum
  import stat_monitor_pkg::*;
#(
  parameter int MAG_W   = 13,
  parameter int ACC_W   = 24,
  parameter int RES_W   = 20,
  parameter int SQ_KEEP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             first,
  input  logic             last,
  input  logic [1:0]       mode,
  input  logic [MAG_W-1:0] mag,
  input  logic [MAG_W-1:0] thresh,
  output logic [RES_W-1:0] result,
  output logic             result_stb
);
  localparam int SQ_W    = 2 * MAG_W;
  localparam int SHIFT   = ACC_W - RES_W;

  logic [ACC_W-1:0] acc_q, acc_d, term, base;
  logic [ACC_W:0]   sum;
  logic [SQ_W-1:0]  sq;
  logic [RES_W-1:0] res_d;
  logic             hit;

  always_comb begin
    sq   = SQ_W'(mag) * SQ_W'(mag);
    hit  = (mag > thresh);
    base = first ? '0 : acc_q;
    term = '0;
    acc_d = '0;
    case (stat_mode_e'(mode))
      MODE_PEAK: begin
        if (first || ACC_W'(mag) > acc_q) acc_d = ACC_W'(mag);
        else                              acc_d = acc_q;
      end
      MODE_POWER: term = ACC_W'(sq[SQ_W-1 -: SQ_KEEP]);
      default:    term = ACC_W'(hit);
    endcase
    sum = {1'b0, base} + {1'b0, term};
    if (stat_mode_e'(mode) != MODE_PEAK)
      acc_d = sum[ACC_W] ? '1 : sum[ACC_W-1:0];

    case (stat_mode_e'(mode))
      MODE_POWER: res_d = acc_d[ACC_W-1:SHIFT];
      MODE_PEAK:  res_d = RES_W'(acc_d[MAG_W-1:0]);
      default:    res_d = (acc_d[ACC_W-1:RES_W] != '0) ? '1 : acc_d[RES_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      result     <= '0;
      result_stb <= 1'b0;
    end else begin
      result_stb <= 1'b0;
      if (en) begin
        acc_q <= acc_d;
        if (last) begin
          result     <= res_d;
          result_stb <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stat_monitor.sv
module stat_monitor #(
  parameter int SAMPLE_W   = 14,
  parameter int PERIOD_W   = 24,
  parameter int ACC_W      = 24,
  parameter int RES_W      = 20,
  parameter int SQ_KEEP    = 11,
  parameter int MIN_PERIOD = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  sync_en,
  input  logic                  sync_in,
  input  logic [SAMPLE_W-1:0]   sample,
  input  logic [PERIOD_W-1:0]   period,
  input  logic [1:0]            mode,
  input  logic [SAMPLE_W-2:0]   thresh,
  output logic [RES_W-1:0]      result,
  output logic                  result_stb
);
  localparam int MAG_W = SAMPLE_W - 1;

  logic [MAG_W-1:0] mag;
  logic first, last, sync_hit;

  assign sync_hit = en && sync_en && sync_in;

  stat_mag #(.SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W)) i_mag (
    .sample(sample), .mag(mag)
  );

  stat_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) i_timer (
    .clk(clk), .rst(rst), .en(en), .sync_hit(sync_hit), .period(period),
    .first(first), .last(last)
  );

  stat_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W), .RES_W(RES_W), .SQ_KEEP(SQ_KEEP)) i_accum (
    .clk(clk), .rst(rst), .en(en), .first(first), .last(last), .mode(mode),
    .mag(mag), .thresh(thresh), .result(result), .result_stb(result_stb)
  );
endmodule

// File: rtl/stat_monitor_chk.sv
module stat_monitor_chk #(
  parameter int RES_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       mode,
  input logic [RES_W-1:0] result,
  input logic             result_stb
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !result_stb));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    result_stb |=> !result_stb);

  a_r7_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !en |=> !result_stb);

  a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
    !result_stb |-> $stable(result));

  a_r3_peak_range: assert property (@(posedge clk) disable iff (rst)
    (result_stb && mode == 2'b01) |-> (result < RES_W'(8192)));
endmodule

bind stat_monitor stat_monitor_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .en(en), .mode(mode),
  .result(result), .result_stb(result_stb)
);

// File: tb/test_stat_monitor.sv
module test_stat_monitor;
  logic        clk = 1'b0;
  logic        rst, en, sync_en, sync_in;
  logic [13:0] sample;
  logic [23:0] period;
  logic [1:0]  mode;
  logic [12:0] thresh;
  logic [19:0] result;
  logic        result_stb;

  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  stat_monitor i_stat_monitor (
    .clk(clk), .rst(rst), .en(en), .sync_en(sync_en), .sync_in(sync_in),
    .sample(sample), .period(period), .mode(mode), .thresh(thresh),
    .result(result), .result_stb(result_stb)
  );

  // reference model state
  bit      m_seed;
  longint  m_cnt, m_acc;
  int      m_res;
  bit      m_stb;

  function automatic int magf(int s);
    int a = (s < 0) ? -s : s;
    return (a > 8191) ? 8191 : a;
  endfunction

  function automatic longint effp(int p);
    return (p < 128) ? 128 : p;
  endfunction

  function automatic longint foldf(bit first, longint acc, int m);
    longint t;
    if (mode == 2'b01) return (first || m > acc) ? m : acc;
    t = (mode == 2'b00) ? ((longint'(m) * m) >> 15) : ((m > thresh) ? 1 : 0);
    t = (first ? 0 : acc) + t;
    return (t > 16777215) ? 16777215 : t;
  endfunction

  function automatic int convf(longint a);
    if (mode == 2'b00) return int'(a >> 4);
    if (mode == 2'b01) return int'(a);
    return (a > 1048575) ? 1048575 : int'(a);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(int s, bit e, bit sy, string tag);
    bit first, hit;
    @(negedge clk);
    sample = 14'(s); en = e; sync_in = sy;
    hit = e && sync_en && sy;
    if (!e) begin
      m_seed = 1; m_stb = 0;
    end else begin
      first = m_seed || hit;
      m_acc = foldf(first, m_acc, magf(s));
      m_stb = 0;
      if (first) begin
        m_cnt = effp(int'(period)) - 1; m_seed = 0;
      end else if (m_cnt == 1) begin
        m_seed = 1; m_stb = 1; m_res = convf(m_acc);
      end else m_cnt--;
    end
    @(posedge clk); #1;
    check(tag, "result_stb", int'(result_stb), int'(m_stb));
    check(m_stb ? tag : "R9", "result", int'(result), m_res);
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; en = 0; sync_en = 0; sync_in = 0; sample = '0;
    period = 24'd128; mode = 2'b01; thresh = 13'd4000;
    m_seed = 1; m_cnt = 0; m_acc = 0; m_res = 0; m_stb = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset result", int'(result), 0);
    check("R1", "reset stb", int'(result_stb), 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1", "post reset result", int'(result), 0);
    check("R1", "post reset stb", int'(result_stb), 0);

    // peak, window 128, includes most negative input
    mode = 2'b01; period = 24'd128;
    for (int i = 0; i < 300; i++) step((i == 40) ? -8192 : rnd_s() / 2, 1, 0, "R3");
    step(0, 0, 0, "R7");

    // window below minimum acts as 128
    period = 24'd5;
    for (int i = 0; i < 260; i++) step(rnd_s(), 1, 0, "R6");
    step(0, 0, 0, "R7");

    // power, random
    mode = 2'b00; period = 24'd200;
    for (int i = 0; i < 420; i++) step(rnd_s(), 1, 0, "R4");
    step(0, 0, 0, "R7");

    // power, saturating accumulator
    period = 24'd10000;
    for (int i = 0; i < 10000; i++) step(-8192, 1, 0, "R4");
    check("R4", "saturated result", int'(result), 20'hFFFFF);
    step(0, 0, 0, "R7");

    // threshold count, both encodings, boundary magnitudes
    mode = 2'b10; period = 24'd150; thresh = 13'd4000;
    for (int i = 0; i < 320; i++)
      step((i % 7 == 0) ? 4000 : (i % 7 == 1) ? -4001 : (i % 7 == 2) ? -4000 : rnd_s(), 1, 0, "R5");
    step(0, 0, 0, "R7");
    mode = 2'b11; thresh = 13'd0;
    for (int i = 0; i < 310; i++) step((i % 3 == 0) ? 0 : rnd_s(), 1, 0, "R5");
    step(0, 0, 0, "R7");

    // back-to-back windows with gap in the middle
    mode = 2'b01; period = 24'd130;
    for (int i = 0; i < 70; i++) step(rnd_s(), 1, 0, "R2");
    for (int i = 0; i < 20; i++) step(8000, 0, 0, "R7");
    for (int i = 0; i < 300; i++) step(rnd_s() / 4, 1, 0, "R2");

    // sync ignored, then honoured
    mode = 2'b00; sync_en = 0;
    for (int i = 0; i < 200; i++) step(rnd_s(), 1, (i == 50), "R8");
    sync_en = 1;
    for (int i = 0; i < 300; i++) step(rnd_s(), 1, (i == 60 || i == 100), "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule